// File: doc/BRIEF.md
# Multi-Mode Quadrature Position Counter

This block keeps a 32-bit shaft position from two encoder lines, A and B. Software selects one of four counting sources. Full quadrature counts every edge on both lines and takes its direction from the phase order. Pulse-with-direction counts rising edges of A and takes the direction from the level of B. The two single-line modes count A upward only or downward only. In the single-line modes an edge-select bit chooses between rising edges of A and both edges of A. The position runs between zero and a programmable ceiling and wraps at either end. A control bit gates counting on and off.

Both encoder lines pass through a synchroniser before the block compares each new sample with the one before it to find edges. Registers are written over a simple write port and read back through a combinational read port. Software may load the count directly, and the block refuses any value above the ceiling. A load strobe copies a stored start value into the count. In quadrature mode, a sample in which both lines change at once is not counted and sets a sticky phase-error output.

Top module: `qpos_counter`

## Requirements
- R1: After reset the count, start value, ceiling, decoder-control word, main-control word and phase-error output are all zero.
- R2: With source field 0 (decoder-control bits 15:14), each edge of A or B moves the count by one. The sequence AB = 00,10,11,01 (A leading) counts up and the reverse order counts down. The count changes three clock edges after an input change.
- R3: With source field 0, a sample in which A and B both change is not counted, and it sets phase_err, which then stays set until reset.
- R4: With source field 1, only rising edges of A count: up when B is high, down when B is low. Falling edges of A and any change of B leave the count unchanged.
- R5: With source field 2 the count increments on A, and with source field 3 it decrements on A. B never changes the count in these modes.
- R6: In source modes 2 and 3, decoder-control bit 11 set makes both edges of A count, and bit 11 clear makes only rising edges of A count.
- R7: Main-control bit 3 clear holds the count against all encoder activity.
- R8: Counting up from the ceiling gives zero, and counting down from zero gives the ceiling.
- R9: A write to byte offset 0x0 loads the count only when the value is not above the ceiling. Otherwise the count keeps its value.
- R10: A one-cycle load_init pulse copies the start value (offset 0x4) into the count.
- R11: An accepted write to the count takes priority over an encoder count event in the same cycle.
- R12: Readback returns the count at 0x0, the start value at 0x4, the ceiling at 0x8, the decoder-control word at 0x28 and the main-control word at 0x2A. The 16-bit words are zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Encoder line A, asynchronous |
| enc_b | input | 1 | Encoder line B, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data (low 16 bits for 16-bit words) |
| load_init | input | 1 | Copy the start value into the count |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Combinational read data |
| pos_count | output | 32 | Current position |
| phase_err | output | 1 | Sticky illegal-transition flag |

## Verification
On every cycle the checker confirms several properties. The count holds while counting is gated off. The wraps at zero and at the ceiling land on the right value. An accepted count write beats a coincident step, and a refused write leaves the count alone. The decoder never asks for both directions at once, and the phase-error flag never clears. Only the directed scenarios can show the per-mode edge rules, with their exact steps under each source setting and edge-select value. They also cover register readback, the load strobe, and the three-edge input latency that the priority case depends on.

// File: rtl/qpos_pkg.sv
package qpos_pkg;
    typedef enum logic [1:0] {
        SRC_QUAD = 2'd0,
        SRC_DIR  = 2'd1,
        SRC_UP   = 2'd2,
        SRC_DOWN = 2'd3
    } src_e;

    localparam int unsigned OFS_POS  = 'h00;
    localparam int unsigned OFS_INIT = 'h04;
    localparam int unsigned OFS_MAX  = 'h08;
    localparam int unsigned OFS_DEC  = 'h28;
    localparam int unsigned OFS_CTL  = 'h2A;

    localparam int SRC_LSB  = 14;
    localparam int EDGE_BIT = 11;
    localparam int EN_BIT   = 3;

    typedef struct packed {
        logic up;
        logic dn;
        logic bad;
    } step_t;
endpackage

// File: rtl/qpos_sync.sv
module qpos_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] dprev
);
    // stages 0..STAGES-1 synchronise; stage STAGES holds the previous sample
    logic [STAGES:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= din;
            for (int i = 1; i <= STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign dout  = stg_q[STAGES-1];
    assign dprev = stg_q[STAGES];
endmodule

// File: rtl/qpos_decode.sv
module qpos_decode
    import qpos_pkg::*;
(
    input  logic  a_cur,
    input  logic  b_cur,
    input  logic  a_prv,
    input  logic  b_prv,
    input  src_e  src,
    input  logic  both_edges,
    output step_t step
);
    logic a_chg, b_chg, a_rise, a_fall, a_hit;

    always_comb begin
        a_chg  = a_cur ^ a_prv;
        b_chg  = b_cur ^ b_prv;
        a_rise = a_cur & ~a_prv;
        a_fall = ~a_cur & a_prv;
        a_hit  = a_rise | (both_edges & a_fall);
        step   = '0;
        unique case (src)
            SRC_QUAD: begin
                // R2: phase order decides direction; R3: double change is illegal
                if (a_chg && b_chg) begin
                    step.bad = 1'b1;
                end else if (a_chg || b_chg) begin
                    step.up = (a_chg && (a_cur != b_cur)) || (b_chg && (a_cur == b_cur));
                    step.dn = ~step.up;
                end
            end
            SRC_DIR: begin
                // R4: rising A counts, B level is the direction
                step.up = a_rise & b_cur;
                step.dn = a_rise & ~b_cur;
            end
            SRC_UP:   step.up = a_hit;   // R5, R6
            SRC_DOWN: step.dn = a_hit;   // R5, R6
            default:  step = '0;
        endcase
    end
endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
    import qpos_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              load_init,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic [CNT_W-1:0]  pos_count,
    output logic              phase_err
);
    localparam int REG16 = 16;
    localparam logic [ADDR_W-1:0] A_POS  = ADDR_W'(OFS_POS);
    localparam logic [ADDR_W-1:0] A_INIT = ADDR_W'(OFS_INIT);
    localparam logic [ADDR_W-1:0] A_MAX  = ADDR_W'(OFS_MAX);
    localparam logic [ADDR_W-1:0] A_DEC  = ADDR_W'(OFS_DEC);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTL);
    localparam logic [CNT_W-1:0]  ONE    = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] pos;
        logic [CNT_W-1:0] init;
        logic [CNT_W-1:0] maxv;
        logic [REG16-1:0] dec;
        logic [REG16-1:0] ctl;
        logic             perr;
    } state_t;

    state_t st_d, st_q;

    logic [1:0] enc_cur, enc_prv;
    step_t      step;
    logic       cnt_en;

    qpos_sync #(.WIDTH(2), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({enc_a, enc_b}),
        .dout  (enc_cur),
        .dprev (enc_prv)
    );

    qpos_decode u_dec (
        .a_cur      (enc_cur[1]),
        .b_cur      (enc_cur[0]),
        .a_prv      (enc_prv[1]),
        .b_prv      (enc_prv[0]),
        .src        (src_e'(st_q.dec[SRC_LSB+1:SRC_LSB])),
        .both_edges (st_q.dec[EDGE_BIT]),
        .step       (step)
    );

    assign cnt_en = st_q.ctl[EN_BIT];   // R7

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (wr_addr)
                A_INIT:  st_d.init = wr_data;
                A_MAX:   st_d.maxv = wr_data;
                A_DEC:   st_d.dec  = wr_data[REG16-1:0];
                A_CTL:   st_d.ctl  = wr_data[REG16-1:0];
                default: ;
            endcase
        end
        // R9/R11: an accepted count write wins; then load; then encoder step
        if (wr_en && wr_addr == A_POS && wr_data <= st_q.maxv) begin
            st_d.pos = wr_data;
        end else if (load_init) begin
            st_d.pos = st_q.init;               // R10
        end else if (cnt_en && step.up) begin
            st_d.pos = (st_q.pos == st_q.maxv) ? '0 : st_q.pos + ONE;      // R8
        end else if (cnt_en && step.dn) begin
            st_d.pos = (st_q.pos == '0) ? st_q.maxv : st_q.pos - ONE;      // R8
        end
        if (cnt_en && step.bad) begin
            st_d.perr = 1'b1;                   // R3
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;                         // R1
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_POS:   rd_data = st_q.pos;
            A_INIT:  rd_data = st_q.init;
            A_MAX:   rd_data = st_q.maxv;
            A_DEC:   rd_data = {{(CNT_W-REG16){1'b0}}, st_q.dec};
            A_CTL:   rd_data = {{(CNT_W-REG16){1'b0}}, st_q.ctl};
            default: rd_data = '0;
        endcase
    end

    assign pos_count = st_q.pos;
    assign phase_err = st_q.perr;
endmodule

// File: rtl/qpos_checker.sv
module qpos_checker #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic              load_init,
    input logic [CNT_W-1:0]  pos,
    input logic [CNT_W-1:0]  maxv,
    input logic              en,
    input logic              st_up,
    input logic              st_dn,
    input logic              st_bad,
    input logic              perr
);
    logic pos_wr;
    assign pos_wr = wr_en && (wr_addr == '0);

    a_r2_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_up && st_dn));

    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        perr |=> perr);

    a_r3_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_bad && !pos_wr && !load_init) |=> $stable(pos));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !pos_wr && !load_init) |=> $stable(pos));

    a_r8_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_up && pos == maxv && !pos_wr && !load_init) |=> pos == '0);

    a_r8_wrap_dn: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_dn && pos == '0 && !pos_wr && !load_init) |=> pos == $past(maxv));

    a_r9_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_wr && wr_data > maxv && !load_init && !(en && (st_up || st_dn))) |=> $stable(pos));

    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_wr && wr_data <= maxv) |=> pos == $past(wr_data));
endmodule

bind qpos_counter qpos_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .load_init (load_init),
    .pos       (pos_count),
    .maxv      (st_q.maxv),
    .en        (cnt_en),
    .st_up     (step.up),
    .st_dn     (step.dn),
    .st_bad    (step.bad),
    .perr      (phase_err)
);

// File: tb/sim_qpos_counter.sv
module sim_qpos_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b0, enc_b = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        load_init = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data, pos_count;
    logic        phase_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    qpos_counter u0 (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .load_init(load_init), .rd_addr(rd_addr), .rd_data(rd_data),
        .pos_count(pos_count), .phase_err(phase_err)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic bus_wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic set_ab(logic a, logic b);
        @(negedge clk);
        enc_a = a; enc_b = b;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 count", pos_count, 0);
        chk("R1 phase_err", {31'b0, phase_err}, 0);
        rd(8'h04, v); chk("R1 init", v, 0);
        rd(8'h08, v); chk("R1 max", v, 0);
        rd(8'h28, v); chk("R1 dec", v, 0);
        rd(8'h2A, v); chk("R1 ctl", v, 0);
    endtask

    task automatic t_quad;
        bus_wr(8'h08, 1000);
        bus_wr(8'h2A, 32'h8);
        bus_wr(8'h28, 32'h0);
        bus_wr(8'h00, 10);
        chk("R9 accept", pos_count, 10);
        set_ab(1, 0); chk("R2 up1", pos_count, 11);
        set_ab(1, 1); chk("R2 up2", pos_count, 12);
        set_ab(0, 1); chk("R2 up3", pos_count, 13);
        set_ab(0, 0); chk("R2 up4", pos_count, 14);
        set_ab(0, 1); chk("R2 dn1", pos_count, 13);
        set_ab(1, 1); chk("R2 dn2", pos_count, 12);
        set_ab(1, 0); chk("R2 dn3", pos_count, 11);
        set_ab(0, 0); chk("R2 dn4", pos_count, 10);
    endtask

    task automatic t_perr;
        set_ab(1, 1);
        chk("R3 no count", pos_count, 10);
        chk("R3 flag set", {31'b0, phase_err}, 1);
        set_ab(0, 0);
        chk("R3 no count 2", pos_count, 10);
        set_ab(1, 0);
        chk("R3 resume", pos_count, 11);
        chk("R3 sticky", {31'b0, phase_err}, 1);
        set_ab(0, 0);
        chk("R3 back", pos_count, 10);
    endtask

    task automatic t_dir;
        bus_wr(8'h28, 32'h4000);
        set_ab(0, 1); chk("R4 B only", pos_count, 10);
        set_ab(1, 1); chk("R4 rise up", pos_count, 11);
        set_ab(0, 1); chk("R4 fall", pos_count, 11);
        set_ab(0, 0); chk("R4 B fall", pos_count, 11);
        set_ab(1, 0); chk("R4 rise dn", pos_count, 10);
        set_ab(0, 0); chk("R4 fall2", pos_count, 10);
    endtask

    task automatic t_single;
        bus_wr(8'h28, 32'h8000);
        set_ab(1, 0); chk("R5 up rise", pos_count, 11);
        set_ab(0, 0); chk("R6 up fall ignored", pos_count, 11);
        set_ab(0, 1); chk("R5 B ignored", pos_count, 11);
        set_ab(0, 0); chk("R5 B ignored 2", pos_count, 11);
        bus_wr(8'h28, 32'h8800);
        set_ab(1, 0); chk("R6 up both rise", pos_count, 12);
        set_ab(0, 0); chk("R6 up both fall", pos_count, 13);
        bus_wr(8'h28, 32'hC000);
        set_ab(1, 0); chk("R5 down rise", pos_count, 12);
        set_ab(0, 0); chk("R6 down fall ignored", pos_count, 12);
        bus_wr(8'h28, 32'hC800);
        set_ab(1, 0); chk("R6 down both rise", pos_count, 11);
        set_ab(0, 0); chk("R6 down both fall", pos_count, 10);
    endtask

    task automatic t_enable;
        logic [31:0] v;
        bus_wr(8'h2A, 32'h0);
        set_ab(1, 0);
        set_ab(0, 0);
        chk("R7 hold", pos_count, 10);
        rd(8'h2A, v); chk("R7 ctl read", v, 0);
        bus_wr(8'h2A, 32'h8);
        chk("R7 still held after enable", pos_count, 10);
    endtask

    task automatic t_wrap;
        bus_wr(8'h08, 5);
        bus_wr(8'h00, 5);
        bus_wr(8'h28, 32'h8000);
        set_ab(1, 0); chk("R8 wrap up", pos_count, 0);
        set_ab(0, 0);
        bus_wr(8'h28, 32'hC000);
        set_ab(1, 0); chk("R8 wrap down", pos_count, 5);
        set_ab(0, 0);
    endtask

    task automatic t_write;
        bus_wr(8'h00, 6); chk("R9 reject", pos_count, 5);
        bus_wr(8'h00, 3); chk("R9 accept below", pos_count, 3);
        bus_wr(8'h00, 5); chk("R9 accept at max", pos_count, 5);
    endtask

    task automatic t_load;
        logic [31:0] v;
        bus_wr(8'h04, 2);
        rd(8'h04, v); chk("R12 init read", v, 2);
        chk("R10 no load yet", pos_count, 5);
        @(negedge clk); load_init = 1'b1;
        @(negedge clk); load_init = 1'b0;
        chk("R10 load", pos_count, 2);
    endtask

    task automatic t_prio;
        bus_wr(8'h08, 1000);
        bus_wr(8'h28, 32'h8000);
        @(negedge clk); enc_a = 1'b1;
        repeat (2) @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h00; wr_data = 7;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R11 write wins", pos_count, 7);
        repeat (4) @(negedge clk);
        chk("R11 step not replayed", pos_count, 7);
        set_ab(0, 0);
    endtask

    task automatic t_readback;
        logic [31:0] v;
        rd(8'h08, v); chk("R12 max", v, 1000);
        rd(8'h28, v); chk("R12 dec", v, 32'h8000);
        rd(8'h2A, v); chk("R12 ctl", v, 32'h8);
        rd(8'h00, v); chk("R12 count", v, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_quad;
        t_perr;
        t_dir;
        t_single;
        t_enable;
        t_wrap;
        t_write;
        t_load;
        t_prio;
        t_readback;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule